// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational datapath core of a small accumulator-style processor. In the same evaluation it takes an operation select, a register operand (the accumulator or an index register), a source operand from memory and the current carry. It returns the new register value and the negative, overflow, zero and carry conditions. The sequencer uses these results in the cycle that issues the operation.

Each operation also produces a four-bit write mask. The mask tells the status register which of the four conditions to load and which to keep. A flag output whose mask bit is clear always reads 0, so the sequencer does not have to qualify stale values. Single-operand operations (shifts, rotates, increment, decrement) act on the register operand. The two test-and-modify operations and the bit test derive their zero condition from the overlap of the two operands rather than from the result. Decimal arithmetic is not part of this block.

Operation codes on `op`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 shift left, 7 shift right, 8 rotate left, 9 rotate right, 10 increment, 11 decrement, 12 bit test, 13 set bits, 14 clear bits, 15 reserved. Mask bit positions on `flag_we`: bit 3 N, bit 2 V, bit 1 Z, bit 0 C.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) gives result = (a + b + carry_in) mod 256 and C = the ninth bit of that sum. V = 1 when a and b share a sign bit and the result's sign bit differs. Mask = 1111.
- R2: Subtract (op 1) gives result = a + NOT b + carry_in mod 256, so carry_in = 1 means no borrow. C = 1 when no borrow occurs. V follows the rule of R1 applied to a and NOT b. Mask = 1111.
- R3: AND, OR and XOR (ops 2, 3, 4) give the bitwise result, with N = result bit 7 and Z = (result == 0). Mask = 1010, so V and C are never written.
- R4: Compare (op 5) returns a unchanged as result. N = bit 7 of (a - b), Z = (a == b) and C = (a >= b, unsigned). Mask = 1011.
- R5: Shift left (op 6) moves a[7] into C and brings 0 into bit 0. Shift right (op 7) moves a[0] into C and brings 0 into bit 7, so N is 0. N and Z follow the result. Mask = 1011.
- R6: Rotate left (op 8) gives {a[6:0], carry_in} with C = a[7]. Rotate right (op 9) gives {carry_in, a[7:1]} with C = a[0]. N and Z follow the result. Mask = 1011.
- R7: Increment (op 10) and decrement (op 11) give a + 1 and a - 1 modulo 256, with N and Z following the result. Mask = 1010, so carry is never written.
- R8: Bit test (op 12) returns a unchanged as result, with N = b[7], V = b[6] and Z = ((a AND b) == 0). Mask = 1110.
- R9: Set bits (op 13) gives a OR b and clear bits (op 14) gives (NOT a) AND b. Both give Z = ((a AND b) == 0). Mask = 0010.
- R10: The reserved code (op 15) returns a unchanged and writes no flag (mask = 0000).
- R11: Every flag output whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation select (codes listed above) |
| opd_a | input | 8 | Register operand; target of single-operand operations |
| opd_b | input | 8 | Source operand from memory |
| carry_in | input | 1 | Current carry condition |
| result | output | 8 | Value to write back to the register or to memory |
| flag_n | output | 1 | Negative condition |
| flag_v | output | 1 | Overflow condition |
| flag_z | output | 1 | Zero condition |
| flag_c | output | 1 | Carry condition (1 = no borrow for subtraction) |
| flag_we | output | 4 | Flag write mask {N, V, Z, C} |

## Verification
Signed overflow and unsigned carry-out can arise from the same addition or subtraction. The operand pairs 0x7F, 0x80 and 0xFF are chosen so that both occur in one evaluation, or one without the other, with the carry input both set and clear. Each vector is judged by recomputing both conditions from integer arithmetic in the bench. Each result is judged against the mask produced in that same evaluation, so a flag that is computed correctly but not masked, or masked but wrong, is reported.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_CMP = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_INC = 4'd10,
    OP_DEC = 4'd11,
    OP_BIT = 4'd12,
    OP_TSB = 4'd13,
    OP_TRB = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    BW_AND = 3'd0,
    BW_OR  = 3'd1,
    BW_XOR = 3'd2,
    BW_SET = 3'd3,
    BW_CLR = 3'd4
  } bw_fn_e;

  // flag write-mask positions
  localparam int unsigned FI_N = 3;
  localparam int unsigned FI_V = 2;
  localparam int unsigned FI_Z = 1;
  localparam int unsigned FI_C = 0;
  localparam int unsigned FLAG_COUNT = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  end

  assign sum  = full[W-1:0];
  assign cout = full[W];
  // signed overflow: like-signed inputs, differently signed sum
  assign ovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         right,
  input  logic         rotate,
  output logic [W-1:0] y,
  output logic         cout
);
  localparam int unsigned MSB = W - 1;

  logic fill;

  always_comb begin
    fill = rotate ? cin : 1'b0;
    if (right) begin
      y    = {fill, a[MSB:1]};
      cout = a[0];
    end else begin
      y    = {a[MSB-1:0], fill};
      cout = a[MSB];
    end
  end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  bw_fn_e       fn,
  output logic [W-1:0] y,
  output logic         overlap_zero
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign y[i] = (fn == BW_OR)  ? (a[i] | b[i])  :
                  (fn == BW_XOR) ? (a[i] ^ b[i])  :
                  (fn == BW_SET) ? (a[i] | b[i])  :
                  (fn == BW_CLR) ? (~a[i] & b[i]) :
                                   (a[i] & b[i]);
  end

  assign overlap_zero = ~|(a & b);

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opd_a,
  input  logic [W-1:0] opd_b,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c,
  output logic [3:0]   flag_we
);
  localparam int unsigned MSB = W - 1;
  localparam logic [FLAG_COUNT-1:0] WE_ALL   = 4'b1111;
  localparam logic [FLAG_COUNT-1:0] WE_NZ    = 4'b1010;
  localparam logic [FLAG_COUNT-1:0] WE_NZC   = 4'b1011;
  localparam logic [FLAG_COUNT-1:0] WE_NVZ   = 4'b1110;
  localparam logic [FLAG_COUNT-1:0] WE_Z     = 4'b0010;
  localparam logic [FLAG_COUNT-1:0] WE_NONE  = 4'b0000;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // adder operand steering
  logic [W-1:0] add_b;
  logic         add_inv;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;

  always_comb begin
    add_b   = opd_b;
    add_inv = 1'b0;
    add_cin = carry_in;
    unique case (op_e)
      OP_SUB: add_inv = 1'b1;
      OP_CMP: begin add_inv = 1'b1; add_cin = 1'b1; end
      OP_INC: begin add_b = '0; add_cin = 1'b1; end
      OP_DEC: begin add_b = '0; add_inv = 1'b1; add_cin = 1'b0; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a(opd_a), .b(add_b), .invert_b(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  // shifter steering
  logic         sh_right;
  logic         sh_rot;
  logic [W-1:0] sh_y;
  logic         sh_cout;

  assign sh_right = (op_e == OP_SHR) || (op_e == OP_ROR);
  assign sh_rot   = (op_e == OP_ROL) || (op_e == OP_ROR);

  alu8_shift #(.W(W)) u_shift (
    .a(opd_a), .cin(carry_in), .right(sh_right), .rotate(sh_rot),
    .y(sh_y), .cout(sh_cout)
  );

  // bitwise steering
  bw_fn_e       bw_fn;
  logic [W-1:0] bw_y;
  logic         bw_zero;

  always_comb begin
    unique case (op_e)
      OP_OR:   bw_fn = BW_OR;
      OP_XOR:  bw_fn = BW_XOR;
      OP_TSB:  bw_fn = BW_SET;
      OP_TRB:  bw_fn = BW_CLR;
      default: bw_fn = BW_AND;
    endcase
  end

  alu8_bitwise #(.W(W)) u_bitwise (
    .a(opd_a), .b(opd_b), .fn(bw_fn), .y(bw_y), .overlap_zero(bw_zero)
  );

  // result and raw flag selection
  logic                  n_raw, v_raw, z_raw, c_raw;
  logic [FLAG_COUNT-1:0] we_sel;

  always_comb begin
    result = opd_a;
    n_raw  = 1'b0;
    v_raw  = 1'b0;
    z_raw  = 1'b0;
    c_raw  = 1'b0;
    we_sel = WE_NONE;
    unique case (op_e)
      OP_ADD, OP_SUB: begin
        result = add_sum;
        n_raw  = add_sum[MSB];
        v_raw  = add_ovf;
        z_raw  = ~|add_sum;
        c_raw  = add_cout;
        we_sel = WE_ALL;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = bw_y;
        n_raw  = bw_y[MSB];
        z_raw  = ~|bw_y;
        we_sel = WE_NZ;
      end
      OP_CMP: begin
        n_raw  = add_sum[MSB];
        z_raw  = ~|add_sum;
        c_raw  = add_cout;
        we_sel = WE_NZC;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result = sh_y;
        n_raw  = sh_y[MSB];
        z_raw  = ~|sh_y;
        c_raw  = sh_cout;
        we_sel = WE_NZC;
      end
      OP_INC, OP_DEC: begin
        result = add_sum;
        n_raw  = add_sum[MSB];
        z_raw  = ~|add_sum;
        we_sel = WE_NZ;
      end
      OP_BIT: begin
        n_raw  = opd_b[MSB];
        v_raw  = opd_b[MSB-1];
        z_raw  = bw_zero;
        we_sel = WE_NVZ;
      end
      OP_TSB, OP_TRB: begin
        result = bw_y;
        z_raw  = bw_zero;
        we_sel = WE_Z;
      end
      default: ;
    endcase
  end

  assign flag_we = we_sel;
  assign flag_n  = n_raw & we_sel[FI_N];
  assign flag_v  = v_raw & we_sel[FI_V];
  assign flag_z  = z_raw & we_sel[FI_Z];
  assign flag_c  = c_raw & we_sel[FI_C];

  // ---------------------------------------------------------------
  // assertions on the settled outputs
  // ---------------------------------------------------------------
  always_comb begin
    p_unwritten_low_r11: assert (({flag_n, flag_v, flag_z, flag_c} & ~flag_we) == 4'b0000)
      else $error("unmasked flag driven high");

    if (op_e == OP_ADD)
      p_add_sum_r1: assert ({flag_c, result} ==
                            ({1'b0, opd_a} + {1'b0, opd_b} + {{W{1'b0}}, carry_in}))
        else $error("add sum/carry mismatch");

    if (op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)
      p_logic_keeps_vc_r3: assert (!flag_we[FI_V] && !flag_we[FI_C])
        else $error("logic op writes V or C");

    if (flag_we[FI_Z] && op_e != OP_BIT && op_e != OP_TSB && op_e != OP_TRB && op_e != OP_CMP)
      p_zero_tracks_result_r3: assert (flag_z == (result == '0))
        else $error("Z does not follow result");

    if (op_e == OP_CMP)
      p_cmp_no_borrow_r4: assert (result == opd_a && flag_c == (opd_a >= opd_b))
        else $error("compare result or carry wrong");

    if (op_e == OP_SHR)
      p_shr_clears_n_r5: assert (!flag_n && flag_c == opd_a[0])
        else $error("shift right N or C wrong");

    if (op_e == OP_INC || op_e == OP_DEC)
      p_incdec_no_carry_r7: assert (!flag_we[FI_C] &&
                                    result == ((op_e == OP_INC) ? opd_a + W'(1) : opd_a - W'(1)))
        else $error("increment/decrement wrong");

    if (op_e == OP_RSV)
      p_reserved_inert_r10: assert (flag_we == 4'b0000 && result == opd_a)
        else $error("reserved code has an effect");
  end

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] opd_a, opd_b;
  logic       carry_in;
  logic [7:0] result;
  logic       flag_n, flag_v, flag_z, flag_c;
  logic [3:0] flag_we;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  alu8_core dut_i (
    .op(op), .opd_a(opd_a), .opd_b(opd_b), .carry_in(carry_in),
    .result(result), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .flag_we(flag_we)
  );

  function automatic string req_of(input int code);
    case (code)
      0:          return "R1";
      1:          return "R2";
      2, 3, 4:    return "R3";
      5:          return "R4";
      6, 7:       return "R5";
      8, 9:       return "R6";
      10, 11:     return "R7";
      12:         return "R8";
      13, 14:     return "R9";
      default:    return "R10";
    endcase
  endfunction

  // behavioural model, integer arithmetic
  function automatic void ref_model(input int code, input int a, input int b, input int c,
                                    output int r, output int fn, output int fv,
                                    output int fz, output int fc, output int we);
    int t;
    int nb;
    fn = 0; fv = 0; fz = 0; fc = 0; r = a; we = 0;
    nb = 255 - b;
    case (code)
      0:  begin t = a + b + c;  r = t % 256; fc = t / 256;
                fv = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0; we = 15; end
      1:  begin t = a + nb + c; r = t % 256; fc = t / 256;
                fv = (((a ^ r) & (nb ^ r) & 128) != 0) ? 1 : 0; we = 15; end
      2:  begin r = a & b; we = 10; end
      3:  begin r = a | b; we = 10; end
      4:  begin r = a ^ b; we = 10; end
      5:  begin r = a; fc = (a >= b) ? 1 : 0; fz = (a == b) ? 1 : 0;
                fn = (((a - b + 256) % 256) >= 128) ? 1 : 0; we = 11; end
      6:  begin r = (a * 2) % 256; fc = a / 128; we = 11; end
      7:  begin r = a / 2; fc = a % 2; we = 11; end
      8:  begin r = (a * 2 + c) % 256; fc = a / 128; we = 11; end
      9:  begin r = a / 2 + c * 128; fc = a % 2; we = 11; end
      10: begin r = (a + 1) % 256; we = 10; end
      11: begin r = (a + 255) % 256; we = 10; end
      12: begin r = a; fn = b / 128; fv = (b / 64) % 2;
                fz = ((a & b) == 0) ? 1 : 0; we = 14; end
      13: begin r = a | b; fz = ((a & b) == 0) ? 1 : 0; we = 2; end
      14: begin r = (255 - a) & b; fz = ((a & b) == 0) ? 1 : 0; we = 2; end
      default: begin r = a; we = 0; end
    endcase
    if (code <= 4 || (code >= 6 && code <= 11)) begin
      fn = r / 128;
      fz = (r == 0) ? 1 : 0;
    end
    // R11: unwritten flags read zero
    if ((we & 8) == 0) fn = 0;
    if ((we & 4) == 0) fv = 0;
    if ((we & 2) == 0) fz = 0;
    if ((we & 1) == 0) fc = 0;
  endfunction

  task automatic apply(input int code, input int a, input int b, input int c);
    int er, en, ev, ez, ec, ew;
    @(negedge clk);
    op       = 4'(code);
    opd_a    = 8'(a);
    opd_b    = 8'(b);
    carry_in = c[0];
    #1;
    ref_model(code, a, b, c, er, en, ev, ez, ec, ew);
    n_checks++;
    if (int'(result) != er || int'(flag_n) != en || int'(flag_v) != ev ||
        int'(flag_z) != ez || int'(flag_c) != ec || int'(flag_we) != ew) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: actual r=%02h nvzc=%0d%0d%0d%0d we=%04b expected r=%02h nvzc=%0d%0d%0d%0d we=%04b",
               req_of(code), code, a, b, c, result, flag_n, flag_v, flag_z, flag_c, flag_we,
               er, en, ev, ez, ec, 4'(ew));
      if ((ew & ~int'(flag_we) & 15) != 0 || ((int'({flag_n, flag_v, flag_z, flag_c}) & ~ew) != 0))
        $display("FAIL R11 mask/flag disagreement: actual we=%04b expected we=%04b", flag_we, 4'(ew));
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int corner[4];
    corner = '{0, 127, 128, 255};
    op = '0; opd_a = '0; opd_b = '0; carry_in = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // reset state: zero inputs, add -> result 0, Z set (R1)
    apply(0, 0, 0, 0);

    // directed boundaries
    apply(0, 8'h7F, 8'h01, 0);   // R1 signed overflow, no carry
    apply(0, 8'hFF, 8'h01, 0);   // R1 carry out, zero result
    apply(0, 8'h80, 8'h80, 1);   // R1 carry and overflow together
    apply(1, 8'h80, 8'h01, 1);   // R2 overflow on subtract
    apply(1, 8'h00, 8'h01, 1);   // R2 borrow
    apply(1, 8'h05, 8'h05, 0);   // R2 borrow from carry_in
    apply(2, 8'hF0, 8'h0F, 1);   // R3 AND to zero, V/C not written
    apply(5, 8'h42, 8'h42, 0);   // R4 equal compare
    apply(5, 8'h01, 8'h02, 1);   // R4 less-than compare
    apply(7, 8'h81, 8'h00, 1);   // R5 shift right clears N
    apply(6, 8'h80, 8'h00, 1);   // R5 shift left carry out, fill 0
    apply(9, 8'h01, 8'h00, 1);   // R6 rotate right through carry
    apply(8, 8'h80, 8'h00, 0);   // R6 rotate left to zero
    apply(10, 8'hFF, 8'h00, 1);  // R7 increment wraps, carry untouched
    apply(11, 8'h00, 8'h00, 0);  // R7 decrement wraps
    apply(12, 8'h00, 8'hC0, 0);  // R8 bit test from operand
    apply(12, 8'h40, 8'h40, 1);  // R8 overlap, Z clear
    apply(13, 8'h0F, 8'h30, 0);  // R9 set bits, no overlap
    apply(14, 8'h0F, 8'h3C, 1);  // R9 clear bits, overlap
    apply(15, 8'hA5, 8'h5A, 1);  // R10 reserved code inert

    // corner grid over every operation, both carry values (R11 on all)
    for (int code = 0; code < 16; code++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            apply(code, corner[i], corner[j], c);

    // random sweep
    for (int k = 0; k < 4000; k++)
      apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule